// File: doc/BRIEF.md
# Oversampling Transmit Frame Gearbox

This block sits between a downlink frame source and a multi-gigabit transceiver whose serial rate is a multiple of the downlink payload rate. It accepts one 64-bit frame per frame period, with the error-correction bits already included, and turns it into a stream of 32-bit transceiver words, one word per clock. The serial link may run at 2.56, 5.12 or 10.24 Gbps. To lower the effective rate back to the 2.56 Gbps payload rate, every frame bit is repeated `RATIO` times in a row, where `RATIO` is a static parameter equal to 1, 2 or 4.

A frame is offered as a single-cycle strobe with its data. Frames are double-buffered. A frame that arrives while another one is still being shifted out waits in a holding register and follows the current frame with no idle word between them. The frame's top bits hold the alignment header, so bit 63 is sent first. Inside each word, the first serial bit is in bit 0.

Top module: `tx_oversample_gearbox`

## Requirements
- R1: While reset is held and in the first cycle after reset, `word_valid` is 0 and `word_data` is all zeros.
- R2: After reset, `word_valid` stays 0 until a frame has been strobed. The first word of a frame is presented two clocks after the clock edge that samples its strobe.
- R3: Output word k of a frame (k = 0 .. 2·RATIO−1) has frame bit 63 − (k·32/RATIO + j/RATIO) in word bit j, using integer division. Word bit 0 is the first bit on the line.
- R4: The RATIO copies of each frame bit sit in adjacent word bit positions. With RATIO = 2, word bits 2i and 2i+1 are always equal.
- R5: Each frame produces exactly 2·RATIO words, presented on consecutive clocks with `word_valid` high.
- R6: The 4-bit header (frame bits 63 down to 60) occupies the lowest 4·RATIO bits of the first word of its frame, with bit 63 in the lowest positions.
- R7: If the next frame is strobed no later than the edge that presents the current frame's second-to-last word, its first word follows the current frame's last word on the very next clock.
- R8: If no frame is waiting when a frame's last word is presented, `word_valid` is 0 and `word_data` is all zeros on the following clocks until the next frame's first word.
- R9: A frame strobed while an earlier frame is still waiting replaces the waiting frame. A frame strobed on the same edge that moves the waiting frame into the shifter is kept and sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Single-cycle strobe: `frame_data` holds a new frame |
| frame_data | input | FRAME_W (64) | Downlink frame, header in the top four bits |
| word_valid | output | 1 | Ready flag: `word_data` carries a frame word |
| word_data | output | WORD_W (32) | Oversampled transceiver word, first serial bit in bit 0 |

## Verification
Two events can fall on the same clock edge. First, the shifter presents the last word of a frame on the edge that moves the waiting frame into the shifter. Second, a new strobe can land on that same edge. The bench places strobes early in a frame, on the load edge itself, and after the shifter has gone idle. It then compares every output cycle against words built from the bit-order rule, so a lost frame, a dropped strobe or a one-cycle gap shows up as a mismatch in both valid flag and data.

// File: rtl/gb_pkg.sv
package gb_pkg;
    // Words needed to carry one oversampled frame.
    function automatic int gb_words_per_frame(input int frame_w, input int word_w, input int ratio);
        return (frame_w * ratio) / word_w;
    endfunction

    // Frame bits carried in one output word.
    function automatic int gb_bits_per_word(input int word_w, input int ratio);
        return word_w / ratio;
    endfunction
endpackage

// File: rtl/gb_frame_buffer.sv
module gb_frame_buffer #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               take,
    output logic               full,
    output logic [FRAME_W-1:0] rd_data
);
    typedef struct packed {
        logic               full;
        logic [FRAME_W-1:0] data;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end else if (take) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full    = st_q.full;
    assign rd_data = st_q.data;

    // R9
    buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (full && rd_data == $past(wr_data)));

    // R9
    buf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !full);
endmodule

// File: rtl/gb_word_expander.sv
module gb_word_expander #(
    parameter int FRAME_W = 64,
    parameter int WORD_W  = 32,
    parameter int RATIO   = 2,
    parameter int IDX_W   = 2
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [WORD_W-1:0]  word
);
    localparam int BITS_PER_WORD = gb_pkg::gb_bits_per_word(WORD_W, RATIO);

    logic [FRAME_W-1:0] aligned;

    // Bring the chunk for this word to the top of the frame.
    assign aligned = frame << (int'(idx) * BITS_PER_WORD);

    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
        assign word[j] = aligned[FRAME_W-1-(j/RATIO)];
    end
endmodule

// File: rtl/tx_oversample_gearbox.sv
module tx_oversample_gearbox #(
    parameter int FRAME_W = 64,
    parameter int WORD_W  = 32,
    parameter int RATIO   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_data,
    output logic               word_valid,
    output logic [WORD_W-1:0]  word_data
);
    localparam int NUM_WORDS = gb_pkg::gb_words_per_frame(FRAME_W, WORD_W, RATIO);
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] act;
        logic [IDX_W-1:0]   idx;
        logic               busy;
        logic [WORD_W-1:0]  word;
        logic               word_vld;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic               buf_full;
    logic [FRAME_W-1:0] buf_data;
    logic               take;
    logic               last;
    logic [WORD_W-1:0]  exp_word;

    gb_frame_buffer #(.FRAME_W(FRAME_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (frame_valid),
        .wr_data(frame_data),
        .take   (take),
        .full   (buf_full),
        .rd_data(buf_data)
    );

    gb_word_expander #(
        .FRAME_W(FRAME_W),
        .WORD_W (WORD_W),
        .RATIO  (RATIO),
        .IDX_W  (IDX_W)
    ) u_exp (
        .frame(st_q.act),
        .idx  (st_q.idx),
        .word (exp_word)
    );

    assign last = st_q.busy && (st_q.idx == LAST_IDX);
    assign take = buf_full && (!st_q.busy || last);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.word     = exp_word;
            st_d.word_vld = 1'b1;
            st_d.idx      = st_q.idx + 1'b1;
        end else begin
            st_d.word     = '0;
            st_d.word_vld = 1'b0;
        end
        if (take) begin
            st_d.act  = buf_data;
            st_d.idx  = '0;
            st_d.busy = 1'b1;
        end else if (last) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.word_vld;
    assign word_data  = st_q.word;

    // R5
    stream_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> word_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> (!word_valid && word_data == '0));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last) |=> (st_q.busy && st_q.idx == $past(st_q.idx) + 1'b1));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && (!st_q.busy || last)) |=> (st_q.busy && st_q.idx == '0));
endmodule

// File: tb/tx_oversample_gearbox_test.sv
module tx_oversample_gearbox_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 64;
    localparam int WW = 32;
    localparam int R  = 2;
    localparam int NW = FW * R / WW;
    localparam int BPW = WW / R;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_valid = 1'b0;
    logic [FW-1:0] frame_data = '0;
    logic          word_valid;
    logic [WW-1:0] word_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_oversample_gearbox #(.FRAME_W(FW), .WORD_W(WW), .RATIO(R)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_valid(frame_valid),
        .frame_data (frame_data),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    function automatic logic [WW-1:0] exp_word(input logic [FW-1:0] f, input int k);
        logic [WW-1:0] w;
        for (int j = 0; j < WW; j++) w[j] = f[FW-1-(k*BPW + j/R)];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives up to three strobes (cycle -1 = none) and compares every cycle
    // against up to three expected frames starting at given sample cycles.
    task automatic run_seq(input logic [FW-1:0] f0, input int s0,
                           input logic [FW-1:0] f1, input int s1,
                           input logic [FW-1:0] f2, input int s2,
                           input logic [FW-1:0] e0, input int t0,
                           input logic [FW-1:0] e1, input int t1,
                           input logic [FW-1:0] e2, input int t2,
                           input int last_c, input string name);
        int run_len = 0;
        for (int c = 0; c <= last_c; c++) begin
            @(negedge clk);
            begin
                bit ev = 1'b0;
                logic [WW-1:0] ed = '0;
                if (t0 >= 0 && c >= t0 && c < t0 + NW) begin ev = 1'b1; ed = exp_word(e0, c - t0); end
                if (t1 >= 0 && c >= t1 && c < t1 + NW) begin ev = 1'b1; ed = exp_word(e1, c - t1); end
                if (t2 >= 0 && c >= t2 && c < t2 + NW) begin ev = 1'b1; ed = exp_word(e2, c - t2); end
                if (ev) begin
                    check(word_valid === 1'b1, {"R5 valid in word window ", name}, 64'(word_valid), 64'd1);
                    check(word_data === ed, {"R3 word content ", name}, 64'(word_data), 64'(ed));
                    check(word_data[1:0] !== 2'b01 && word_data[1:0] !== 2'b10 &&
                          word_data[31:30] !== 2'b01 && word_data[31:30] !== 2'b10,
                          {"R4 adjacent copies ", name}, 64'(word_data), 64'(ed));
                    run_len++;
                end else begin
                    check(word_valid === 1'b0 && word_data === '0, {"R8 idle between frames ", name},
                          {31'd0, word_valid, word_data}, 64'd0);
                end
            end
            frame_valid = (c == s0) || (c == s1) || (c == s2);
            frame_data  = (c == s0) ? f0 : (c == s1) ? f1 : (c == s2) ? f2 : '0;
        end
        frame_valid = 1'b0;
        frame_data  = '0;
        check(run_len == NW * (1 + int'(t1 >= 0) + int'(t2 >= 0)), {"R5 word count ", name},
              64'(run_len), 64'(NW * (1 + int'(t1 >= 0) + int'(t2 >= 0))));
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(word_valid === 1'b0 && word_data === '0, "R1 in reset", {31'd0, word_valid, word_data}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_valid === 1'b0 && word_data === '0, "R1 after reset", {31'd0, word_valid, word_data}, 64'd0);
        repeat (5) @(negedge clk);
        check(word_valid === 1'b0, "R2 no word before first frame", 64'(word_valid), 64'd0);
    endtask

    task automatic test_first_frame();
        logic [FW-1:0] f = 64'hA5F0_1234_C3C3_9E01;
        logic [WW-1:0] hdr_exp = '0;
        // Strobe at edge 0: samples 1 and 2 stay quiet, first word visible at sample 3.
        run_seq(f, 0, '0, -1, '0, -1, f, 3, '0, -1, '0, -1, 9, "single");
        for (int i = 0; i < 4; i++) begin
            hdr_exp[2*i]   = f[63-i];
            hdr_exp[2*i+1] = f[63-i];
        end
        check(exp_word(f, 0) [4*R-1:0] === hdr_exp[4*R-1:0], "R6 header in first word",
              64'(exp_word(f, 0)), 64'(hdr_exp));
    endtask

    task automatic test_header_live();
        logic [FW-1:0] f = 64'h6000_0000_0000_0000;
        logic [WW-1:0] seen = '0;
        @(negedge clk);
        frame_valid = 1'b1; frame_data = f;
        @(negedge clk);
        frame_valid = 1'b0; frame_data = '0;
        @(negedge clk);
        @(negedge clk);
        seen = word_data;
        // Header 4'b0110 sent MSB first: bits 63..60 = 0,1,1,0 -> pairs 00,11,11,00.
        check(word_valid === 1'b1 && seen[7:0] === 8'b0011_1100, "R6 header first on line",
              64'(seen), 64'h3C);
        check(seen[WW-1:8] === '0, "R3 rest of first word", 64'(seen), 64'd0);
        repeat (NW + 2) @(negedge clk);
    endtask

    task automatic test_back_to_back();
        run_seq(64'h0123_4567_89AB_CDEF, 0, 64'hFEDC_BA98_7654_3210, 2, '0, -1,
                64'h0123_4567_89AB_CDEF, 3, 64'hFEDC_BA98_7654_3210, 7, '0, -1, 13, "back-to-back R7");
        run_seq(64'hFFFF_0000_FFFF_0000, 0, 64'h8000_0000_0000_0001, 4, '0, -1,
                64'hFFFF_0000_FFFF_0000, 3, 64'h8000_0000_0000_0001, 7, '0, -1, 13, "latest strobe R7");
    endtask

    task automatic test_underrun();
        run_seq(64'h1111_2222_3333_4444, 0, 64'hDEAD_BEEF_CAFE_F00D, 6, '0, -1,
                64'h1111_2222_3333_4444, 3, 64'hDEAD_BEEF_CAFE_F00D, 9, '0, -1, 15, "gap R8");
    endtask

    task automatic test_overwrite();
        run_seq(64'hAAAA_5555_AAAA_5555, 0, 64'h0F0F_0F0F_0F0F_0F0F, 1, 64'h7777_8888_9999_0000, 2,
                64'hAAAA_5555_AAAA_5555, 3, 64'h7777_8888_9999_0000, 7, '0, -1, 13, "replace R9");
        run_seq(64'hC001_C0DE_0000_FFFF, 0, 64'h1234_5678_9ABC_DEF0, 1, 64'h0000_FFFF_1357_2468, 5,
                64'hC001_C0DE_0000_FFFF, 3, 64'h1234_5678_9ABC_DEF0, 7, 64'h0000_FFFF_1357_2468, 11,
                17, "strobe on load edge R9");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_first_frame();
        test_header_live();
        test_back_to_back();
        test_underrun();
        test_overwrite();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule